// File: doc/BRIEF.md
# Store-Load Overlap Detector

The detector keeps a short list of the stores issued so far in the current dispatch group. It reports whether an incoming load touches bytes that one of those stores writes. Each store record holds three fields: a base identifier, a signed byte offset from that base, and a length in bytes. A load query carries the same three fields. A load hits a record when the two share a base and their byte ranges intersect. A load also hits a record when the two share both base and offset, whatever the lengths. The scheduler around the block decides where a group ends and what to do on a hit. At each group boundary it pulses the clear input.

A small fill controller tracks how many records are held. It has three states:

| State | Meaning |
|---|---|
| `FILL_EMPTY` | No records are held. |
| `FILL_PART` | Some records are held, but not all slots are used. |
| `FILL_FULL` | Every slot is used. |

It moves between them on these transitions:

| Transition | Condition |
|---|---|
| `FILL_EMPTY` to `FILL_PART` | A store is accepted and slots remain afterwards. |
| `FILL_EMPTY` or `FILL_PART` to `FILL_FULL` | A store takes the last free slot. |
| `FILL_PART` or `FILL_FULL` to `FILL_EMPTY` | Clear is pulsed. |
| Any state to itself | None of the above applies. |

A store that arrives in `FILL_FULL` is dropped. Every occupied slot is compared with the query in parallel, and the per-slot results are ORed together. The answer is registered.

Top module: `sld_overlap_det`

## Requirements
- R1: After reset no record is held and `ld_rsp_vld_o` is low, so a query answers with `ld_hit_o` = 0.
- R2: A load whose base and offset both equal those of a held record hits, even when both lengths are zero.
- R3: When the bases match and the record offset is below the load offset, the load hits exactly when record offset plus record length is greater than the load offset.
- R4: When the bases match and the record offset is at or above the load offset, the load hits exactly when load offset plus load length is greater than the record offset.
- R5: A record whose base differs from the load base never causes a hit, whatever the offsets.
- R6: At most DEPTH (default 4) records are held. A store arriving while all are held is dropped.
- R7: A clear pulse empties every record. A store presented in the same cycle as clear is dropped.
- R8: A store accepted in cycle t is seen by queries presented from cycle t+1 on, but not by a query in cycle t.
- R9: Each query presented in cycle t gives `ld_rsp_vld_o` = 1 in cycle t+1 with the hit result. Without a query, `ld_rsp_vld_o` is 0.
- R10: Offsets are two's-complement values of OFF_W bits, and lengths are unsigned. Offset plus length is formed without wrap-around, so ranges near the signed limits and below zero compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Group boundary: empties all records |
| st_vld_i | input | 1 | Store record strobe |
| st_base_i | input | BASE_W | Store base identifier |
| st_off_i | input | OFF_W | Store offset, signed |
| st_size_i | input | SIZE_W | Store length in bytes |
| ld_vld_i | input | 1 | Load query strobe |
| ld_base_i | input | BASE_W | Load base identifier |
| ld_off_i | input | OFF_W | Load offset, signed |
| ld_size_i | input | SIZE_W | Load length in bytes |
| ld_rsp_vld_o | output | 1 | Query answer valid, one cycle after the query |
| ld_hit_o | output | 1 | Load overlaps at least one held store |

## Verification
The comparison is exercised with one record placed at a known offset and loads moved around it:
- a load at exactly the same offset with zero lengths;
- a load starting one byte inside the record's end and one starting exactly at it, which separates greater-than from greater-or-equal in R3;
- loads ending exactly at the record start and one byte past it, which do the same for R4;
- a load with a different base.

Negative offsets, and a record near the largest positive offset with the widest length, show whether the sums are signed and carry their extra bit.

Four records followed by a fifth store, a store together with clear, and a store together with a query separate capacity, clear priority and the one-cycle visibility rule.

// File: rtl/sld_pkg.sv
package sld_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/sld_fill_fsm.sv
module sld_fill_fsm
    import sld_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             st_vld_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [CNT_W-1:0] fill_cnt_o
);

    localparam logic [CNT_W-1:0] LAST_FREE = CNT_W'(DEPTH - 1);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (!clr_i && st_vld_i) begin
                    state_d = (DEPTH == 1) ? FILL_FULL : FILL_PART;
                end
            end
            FILL_PART: begin
                if (clr_i) begin
                    state_d = FILL_EMPTY;
                end else if (st_vld_i && cnt_q == LAST_FREE) begin
                    state_d = FILL_FULL;
                end
            end
            FILL_FULL: begin
                if (clr_i) begin
                    state_d = FILL_EMPTY;
                end
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en_o = 1'b0;
        unique case (state_q)
            FILL_EMPTY,
            FILL_PART: wr_en_o = st_vld_i && !clr_i;
            FILL_FULL: wr_en_o = 1'b0;
            default:   wr_en_o = 1'b0;
        endcase
        wr_idx_o   = cnt_q[IDX_W-1:0];
        fill_cnt_o = cnt_q;
    end

    // Occupancy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (wr_en_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sld_slot.sv
module sld_slot #(
    parameter int BASE_W = 16,
    parameter int OFF_W  = 64,
    parameter int SIZE_W = 16,
    localparam int EXT_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BASE_W-1:0] st_base_i,
    input  logic [OFF_W-1:0]  st_off_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              occ_i,
    input  logic [BASE_W-1:0] ld_base_i,
    input  logic [OFF_W-1:0]  ld_off_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    output logic              hit_o
);

    logic        [BASE_W-1:0] r_base;
    logic signed [OFF_W-1:0]  r_off;
    logic        [SIZE_W-1:0] r_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_base <= '0;
            r_off  <= '0;
            r_size <= '0;
        end else if (we_i) begin
            r_base <= st_base_i;
            r_off  <= $signed(st_off_i);
            r_size <= st_size_i;
        end
    end

    logic signed [OFF_W-1:0] q_off;
    logic signed [EXT_W-1:0] r_lo, r_hi, q_lo, q_hi;
    logic                    same_base, same_off, rec_below;

    // Widen by one bit so offset plus length never wraps
    always_comb begin
        q_off     = $signed(ld_off_i);
        r_lo      = EXT_W'(r_off);
        q_lo      = EXT_W'(q_off);
        r_hi      = r_lo + $signed(EXT_W'(r_size));
        q_hi      = q_lo + $signed(EXT_W'(ld_size_i));
        same_base = occ_i && (r_base == ld_base_i);
        same_off  = (r_off == q_off);
        rec_below = (r_off < q_off);
        if (!same_base) begin
            hit_o = 1'b0;
        end else if (same_off) begin
            hit_o = 1'b1;
        end else if (rec_below) begin
            hit_o = (r_hi > q_lo);
        end else begin
            hit_o = (q_hi > r_lo);
        end
    end

endmodule

// File: rtl/sld_overlap_det.sv
module sld_overlap_det #(
    parameter int DEPTH  = 4,
    parameter int BASE_W = 16,
    parameter int OFF_W  = 64,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              st_vld_i,
    input  logic [BASE_W-1:0] st_base_i,
    input  logic [OFF_W-1:0]  st_off_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              ld_vld_i,
    input  logic [BASE_W-1:0] ld_base_i,
    input  logic [OFF_W-1:0]  ld_off_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    output logic              ld_rsp_vld_o,
    output logic              ld_hit_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [CNT_W-1:0] fill_cnt;
    logic [DEPTH-1:0] slot_hit;

    sld_fill_fsm #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .st_vld_i   (st_vld_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .fill_cnt_o (fill_cnt)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sld_slot #(
            .BASE_W (BASE_W),
            .OFF_W  (OFF_W),
            .SIZE_W (SIZE_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (wr_en && (wr_idx == IDX_W'(i))),
            .st_base_i (st_base_i),
            .st_off_i  (st_off_i),
            .st_size_i (st_size_i),
            .occ_i     (CNT_W'(i) < fill_cnt),
            .ld_base_i (ld_base_i),
            .ld_off_i  (ld_off_i),
            .ld_size_i (ld_size_i),
            .hit_o     (slot_hit[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_rsp_vld_o <= 1'b0;
            ld_hit_o     <= 1'b0;
        end else begin
            ld_rsp_vld_o <= ld_vld_i;
            ld_hit_o     <= ld_vld_i && (|slot_hit);
        end
    end

endmodule

// File: rtl/sld_overlap_det_chk.sv
module sld_overlap_det_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             st_vld_i,
    input logic             ld_vld_i,
    input logic             ld_rsp_vld_o,
    input logic             ld_hit_o,
    input logic [CNT_W-1:0] fill_cnt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic clr_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_d <= 1'b0;
        else        clr_d <= clr_i;
    end

    a_r9_rsp_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_i |=> ld_rsp_vld_o);

    a_r9_no_rsp_without_query: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_vld_i |=> !ld_rsp_vld_o);

    a_r9_hit_implies_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit_o |-> ld_rsp_vld_o);

    a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= FULL_CNT);

    a_r6_full_drops_store: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == FULL_CNT && st_vld_i && !clr_i) |=> fill_cnt == FULL_CNT);

    a_r8_store_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld_i && !clr_i && fill_cnt < FULL_CNT) |=> fill_cnt == $past(fill_cnt) + 1'b1);

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> fill_cnt == '0);

    a_r7_query_after_clear_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_d && ld_vld_i) |=> !ld_hit_o);

endmodule

bind sld_overlap_det sld_overlap_det_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .st_vld_i     (st_vld_i),
    .ld_vld_i     (ld_vld_i),
    .ld_rsp_vld_o (ld_rsp_vld_o),
    .ld_hit_o     (ld_hit_o),
    .fill_cnt     (fill_cnt)
);

// File: tb/sld_overlap_det_bench.sv
`timescale 1ns/1ps
module sld_overlap_det_bench;

    localparam int BASE_W = 16;
    localparam int OFF_W  = 64;
    localparam int SIZE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_i = 1'b0;
    logic              st_vld_i = 1'b0;
    logic [BASE_W-1:0] st_base_i = '0;
    logic [OFF_W-1:0]  st_off_i = '0;
    logic [SIZE_W-1:0] st_size_i = '0;
    logic              ld_vld_i = 1'b0;
    logic [BASE_W-1:0] ld_base_i = '0;
    logic [OFF_W-1:0]  ld_off_i = '0;
    logic [SIZE_W-1:0] ld_size_i = '0;
    logic              ld_rsp_vld_o;
    logic              ld_hit_o;

    int errors = 0;
    int checks = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    sld_overlap_det u_sld_overlap_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .st_vld_i     (st_vld_i),
        .st_base_i    (st_base_i),
        .st_off_i     (st_off_i),
        .st_size_i    (st_size_i),
        .ld_vld_i     (ld_vld_i),
        .ld_base_i    (ld_base_i),
        .ld_off_i     (ld_off_i),
        .ld_size_i    (ld_size_i),
        .ld_rsp_vld_o (ld_rsp_vld_o),
        .ld_hit_o     (ld_hit_o)
    );

    // One cycle of stimulus, driven on the falling edge
    task automatic drive(input bit clr, input bit sv, input int sb, input longint so,
                         input int ss, input bit lv, input int lb, input longint lo,
                         input int ls, input bit exp, input string tag);
        @(negedge clk);
        clr_i     = clr;
        st_vld_i  = sv;
        st_base_i = BASE_W'(sb);
        st_off_i  = OFF_W'(so);
        st_size_i = SIZE_W'(ss);
        ld_vld_i  = lv;
        ld_base_i = BASE_W'(lb);
        ld_off_i  = OFF_W'(lo);
        ld_size_i = SIZE_W'(ls);
        if (lv) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic store(input int b, input longint o, input int s);
        drive(0, 1, b, o, s, 0, 0, 0, 0, 0, "");
        idle();
    endtask

    task automatic query(input int b, input longint o, input int s, input bit exp,
                         input string tag);
        drive(0, 0, 0, 0, 0, 1, b, o, s, exp, tag);
    endtask

    task automatic clear();
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        idle();
    endtask

    // Monitor: answers appear one cycle after the query (R9)
    always @(posedge clk) begin
        #1;
        if (rst_n && ld_rsp_vld_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected response, actual rsp_vld=1 expected 0");
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (ld_hit_o !== e) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b expected %0b", t, ld_hit_o, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (ld_rsp_vld_o !== 1'b0 || ld_hit_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual rsp=%0b hit=%0b expected 0 0", ld_rsp_vld_o, ld_hit_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        query(1, 100, 8, 0, "R1");
        idle();

        // One record at base 1, bytes 100..107
        store(1, 100, 8);
        query(1, 100, 0, 1, "R2");
        query(1, 107, 1, 1, "R3");
        query(1, 108, 4, 0, "R3");
        query(1, 96, 4, 0, "R4");
        query(1, 96, 5, 1, "R4");
        query(2, 100, 8, 0, "R5");
        query(2, 104, 1, 0, "R5");
        idle();

        clear();
        query(1, 100, 8, 0, "R7");
        idle();

        // Negative offsets and top of the signed range
        store(3, -16, 16);
        store(4, 64'sh7FFF_FFFF_FFFF_FFF0, 16'hFFFF);
        query(3, -1, 1, 1, "R10");
        query(3, 0, 1, 0, "R10");
        query(3, -20, 4, 0, "R10");
        query(4, 64'sh7FFF_FFFF_FFFF_FFFF, 1, 1, "R10");
        idle();

        // Capacity
        clear();
        for (int k = 0; k < 4; k++) store(10 + k, 0, 4);
        store(14, 0, 4);
        query(13, 2, 1, 1, "R6");
        query(10, 0, 1, 1, "R6");
        query(14, 0, 4, 0, "R6");
        idle();

        // Clear wins over a store in the same cycle
        drive(1, 1, 20, 0, 4, 0, 0, 0, 0, 0, "");
        idle();
        query(20, 0, 4, 0, "R7");
        query(10, 0, 4, 0, "R7");
        idle();

        // Store and query in the same cycle
        drive(0, 1, 30, 0, 8, 1, 30, 0, 8, 0, "R8");
        query(30, 0, 8, 1, "R8");
        idle();
        idle();

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: actual %0d answers missing expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule